// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer driven entirely through a small set of 32-bit registers. Software arms the watchdog and keeps it alive by writing 16-bit magic words to a key register. The divider setting and the 12-bit reload value can only be changed after an unlock word has been written. Once armed, the watchdog cannot be disarmed by software. If software stops refreshing it, the block raises a one-cycle reset request.

The slow, separate counting clock is modelled by a clock-enable input, `tick_en`, that runs in the system clock domain. A new divider or reload setting does not take effect at once. It takes a fixed number of ticks to reach the counting logic. Until then a busy bit in the status register is set, so software can tell when the new setting has been applied. Each key, divider and reload register sits on a 32-bit word boundary. The byte addresses are: key 0x0, divider 0x4, reload 0x8, status 0xC.

Top module: `kwdt_top`

## Requirements
- R1: After reset the reload register reads 0x00000FFF, the divider register reads 0, the status register reads 0, `rst_req` is low and the watchdog is not running.
- R2: A read of the key register (0x0) always returns 0. A read of the divider, reload or status register returns zeros above its field: 3 bits at [2:0] for the divider, 12 bits at [11:0] for the reload, 2 bits at [1:0] for the status. A write to an address with nonzero low two bits is ignored.
- R3: A key write of 0x00005555 permits writes to the divider and reload registers. Any other key write withdraws that permission. A divider or reload write made without permission leaves that register unchanged and sets no busy bit.
- R4: An accepted reload write sets status bit 1, and an accepted divider write sets status bit 0. The bit stays set for exactly 3 `tick_en` cycles and then clears. The new value is used for counting from the cycle in which the bit clears.
- R5: A key write of 0x0000CCCC starts the watchdog and loads the counter with the reload value RL. With `tick_en` high, the first `rst_req` pulse appears (RL+1)·D clock cycles after the write edge, where D is the divider.
- R6: Divider code c in the range 0 to 6 gives D = 4·2^c. Code 7 gives D = 256.
- R7: A key write of 0x0000AAAA reloads the counter and restarts the divider phase. If this refresh falls in the same cycle as the expiring tick, the refresh takes priority and no pulse is produced.
- R8: When the counter is at zero and a divided tick arrives, `rst_req` goes high for exactly one cycle and the counter reloads and keeps running. Only a system reset stops the watchdog.
- R9: The divider and the counter advance only in cycles where `tick_en` is high. While `tick_en` is low, no reset request is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Counting-clock enable, one pulse per slow-clock tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
Two events can fall in the same clock edge: a refresh key write and the divided tick that would expire the counter. The bench arms the watchdog with a short reload and divider, then issues the refresh exactly (RL+1)·D edges after the start write. The scoreboard must see no pulse at that edge. It must instead see the next pulse one full period after the refresh, which shows that the refresh won and that the divider phase restarted with it.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int REG_W = 32;
  localparam int KEY_W = 16;

  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

  typedef enum logic [1:0] {
    SEL_KEY = 2'd0,
    SEL_DIV = 2'd1,
    SEL_RLD = 2'd2,
    SEL_STS = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/kwdt_cfg_sync.sv
module kwdt_cfg_sync #(
  parameter int             W       = 12,
  parameter logic [W-1:0]   RST_VAL = '1,
  parameter int             TICKS   = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         busy
);
  localparam int CW = $clog2(TICKS + 1);

  logic [W-1:0]  shadow_q, shadow_d;
  logic [W-1:0]  active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    shadow_d = shadow_q;
    active_d = active_q;
    cnt_d    = cnt_q;
    if (load) begin
      shadow_d = load_val;
      cnt_d    = CW'(TICKS);
    end else if (tick_en && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) active_d = shadow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RST_VAL;
      active_q <= RST_VAL;
      cnt_q    <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign shadow = shadow_q;
  assign active = active_q;
  assign busy   = (cnt_q != '0);

  // R4: without a tick and without a new write, a pending transfer stays pending
  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_en && !load) |=> busy);
  // R4: the counting value never moves while no transfer is pending
  p_active_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(active_q));
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             running,
  input  logic             kick,
  input  logic [PSC_W-1:0] code,
  output logic             dec
);
  localparam int TOP_CODE  = (1 << PSC_W) - 1;
  localparam int MAX_SHIFT = TOP_CODE - 1;
  localparam int MAX_DIV   = 4 << MAX_SHIFT;
  localparam int CNT_W     = $clog2(MAX_DIV);

  logic [PSC_W-1:0] shift;
  logic [CNT_W:0]   div_val;
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] pcnt_q, pcnt_d;
  logic             at_term;

  // highest code repeats the largest divider
  assign shift   = (code == PSC_W'(TOP_CODE)) ? PSC_W'(MAX_SHIFT) : code;
  assign div_val = (CNT_W + 1)'(4) << shift;
  assign term    = CNT_W'(div_val - 1'b1);
  assign at_term = (pcnt_q >= term);
  assign dec     = running && tick_en && at_term;

  always_comb begin
    pcnt_d = pcnt_q;
    if (kick)                     pcnt_d = '0;
    else if (running && tick_en)  pcnt_d = at_term ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R9: the divider phase holds in cycles without a tick
  p_phase_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !kick) |=> $stable(pcnt_q));
  // R7: a refresh restarts the divider phase
  p_kick_clears_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (pcnt_q == '0));
endmodule

// File: rtl/kwdt_downcnt.sv
module kwdt_downcnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dec,
  input  logic         kick,
  input  logic [W-1:0] reload,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         exp_q, exp_d;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (kick) begin
      cnt_d = reload;
    end else if (dec) begin
      if (cnt_q == '0) begin
        cnt_d = reload;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expire = exp_q;

  // R8: the request never lasts longer than one cycle
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |=> !exp_q);
  // R7: a refresh loads the counter and suppresses a request in the same edge
  p_kick_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == $past(reload)) && !exp_q);
endmodule

// File: rtl/kwdt_regif.sv
module kwdt_regif
  import kwdt_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int RLD_W      = 12,
  parameter int PSC_W      = 3,
  parameter int SYNC_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              kick,
  output logic              running,
  output logic [PSC_W-1:0]  psc_act,
  output logic [RLD_W-1:0]  rld_act
);
  logic             hi_zero;
  logic             hit;
  reg_sel_e         sel;
  logic [KEY_W-1:0] key;
  logic             key_clean;
  logic             key_wr;
  logic             unlocked_q, unlocked_d;
  logic             running_q, running_d;
  logic             psc_load, rld_load;
  logic [PSC_W-1:0] psc_shadow;
  logic [RLD_W-1:0] rld_shadow;
  logic             psc_busy, rld_busy;

  generate
    if (ADDR_W > 4) begin : g_hi_addr
      assign hi_zero = (addr[ADDR_W-1:4] == '0);
    end else begin : g_no_hi_addr
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign hit       = wr_en && hi_zero && (addr[1:0] == 2'b00);
  assign sel       = reg_sel_e'(addr[3:2]);
  assign key       = wdata[KEY_W-1:0];
  assign key_clean = (wdata[REG_W-1:KEY_W] == '0);
  assign key_wr    = hit && (sel == SEL_KEY);
  assign psc_load  = hit && (sel == SEL_DIV) && unlocked_q;
  assign rld_load  = hit && (sel == SEL_RLD) && unlocked_q;
  assign kick      = key_wr && key_clean && ((key == KEY_START) || (key == KEY_REFRESH));

  always_comb begin
    unlocked_d = unlocked_q;
    running_d  = running_q;
    if (key_wr) begin
      unlocked_d = key_clean && (key == KEY_UNLOCK);
      if (key_clean && (key == KEY_START)) running_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      running_q  <= 1'b0;
    end else begin
      unlocked_q <= unlocked_d;
      running_q  <= running_d;
    end
  end

  kwdt_cfg_sync #(.W(PSC_W), .RST_VAL('0), .TICKS(SYNC_TICKS)) u_div_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .load    (psc_load),
    .load_val(wdata[PSC_W-1:0]),
    .shadow  (psc_shadow),
    .active  (psc_act),
    .busy    (psc_busy)
  );

  kwdt_cfg_sync #(.W(RLD_W), .RST_VAL('1), .TICKS(SYNC_TICKS)) u_rld_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .load    (rld_load),
    .load_val(wdata[RLD_W-1:0]),
    .shadow  (rld_shadow),
    .active  (rld_act),
    .busy    (rld_busy)
  );

  always_comb begin
    unique case (sel)
      SEL_KEY: rdata = '0;
      SEL_DIV: rdata = {{(REG_W-PSC_W){1'b0}}, psc_shadow};
      SEL_RLD: rdata = {{(REG_W-RLD_W){1'b0}}, rld_shadow};
      default: rdata = {{(REG_W-2){1'b0}}, rld_busy, psc_busy};
    endcase
  end

  assign running = running_q;

  // R3: a reload write without permission leaves the register untouched
  p_locked_rld_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (sel == SEL_RLD) && !unlocked_q) |=> $stable(rld_shadow));
  // R4: an accepted divider write raises its busy bit
  p_div_busy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    psc_load |=> psc_busy);
  // R8: software cannot stop a running watchdog
  p_running_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |=> running_q);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int RLD_W      = 12,
  parameter int PSC_W      = 3,
  parameter int SYNC_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              rst_req
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             kick;
  logic             running;
  logic             dec;
  logic [PSC_W-1:0] psc_act;
  logic [RLD_W-1:0] rld_act;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  kwdt_regif #(
    .ADDR_W(ADDR_W), .RLD_W(RLD_W), .PSC_W(PSC_W), .SYNC_TICKS(SYNC_TICKS)
  ) u_regif (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_en(tick_en),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .kick   (kick),
    .running(running),
    .psc_act(psc_act),
    .rld_act(rld_act)
  );

  kwdt_prescaler #(.PSC_W(PSC_W)) u_prescaler (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_en(tick_en),
    .running(running),
    .kick   (kick),
    .code   (psc_act),
    .dec    (dec)
  );

  kwdt_downcnt #(.W(RLD_W)) u_downcnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .dec   (dec),
    .kick  (kick),
    .reload(rld_act),
    .expire(rst_req)
  );

  // R5: a reset request only ever comes from a started watchdog
  p_req_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_req |-> running);
  // R9: no request follows a cycle without a tick
  p_req_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !tick_en |=> !rst_req);
endmodule

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_KEY = 4'h0, A_DIV = 4'h4, A_RLD = 4'h8, A_STS = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rst_req;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int exp_q[$];
  string tag_q[$];

  kwdt_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, output int kc);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    kc = cyc;
  endtask

  task automatic expect_pulse(int at, string tag);
    exp_q.push_back(at);
    tag_q.push_back(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req) begin
        if (exp_q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R8 unexpected pulse: actual cycle %0d expected none", cyc);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, cyc, e);
        end
      end else if (exp_q.size() > 0 && cyc > exp_q[0]) begin
        n_tests++; n_fail++;
        $display("FAIL %s missed pulse: actual none expected cycle %0d", tag_q[0], exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int kc;
    rst_n = 1'b0; tick_en = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
    do_reset();

    // R1 reset state, R2 readback rules
    chk("R1 rst_req low", {31'b0, rst_req}, 32'h0);
    rd_chk("R1 reload reset", A_RLD, 32'h0000_0FFF);
    rd_chk("R1 divider reset", A_DIV, 32'h0);
    rd_chk("R1 status reset", A_STS, 32'h0);
    rd_chk("R2 key reads zero", A_KEY, 32'h0);
    idle(40);
    chk("R1 idle no pulse", exp_q.size(), 0);

    // R3 protected writes ignored
    wr(A_RLD, 32'h5, kc);
    rd_chk("R3 locked reload", A_RLD, 32'h0000_0FFF);
    rd_chk("R3 locked no busy", A_STS, 32'h0);

    // R2 reserved bits and misaligned writes
    wr(A_KEY, 32'h5555, kc);
    wr(A_RLD, 32'hFFFF_F123, kc);
    rd_chk("R2 reload upper zero", A_RLD, 32'h0000_0123);
    wr(A_DIV, 32'hFFFF_FFFA, kc);
    rd_chk("R2 divider upper zero", A_DIV, 32'h2);
    wr(4'h9, 32'h77, kc);
    rd_chk("R2 misaligned ignored", A_RLD, 32'h0000_0123);
    rd_chk("R2 key still zero", A_KEY, 32'h0);
    idle(4);

    // R4 busy timing, R3 relock
    wr(A_RLD, 32'h5, kc);
    rd_chk("R4 reload busy set", A_STS, 32'h2);
    idle(2);
    rd_chk("R4 reload busy after 2 ticks", A_STS, 32'h2);
    idle(1);
    rd_chk("R4 reload busy cleared", A_STS, 32'h0);
    wr(A_DIV, 32'h1, kc);
    rd_chk("R4 divider busy set", A_STS, 32'h1);
    wr(A_KEY, 32'h1234, kc);
    wr(A_RLD, 32'h9, kc);
    rd_chk("R3 relocked reload kept", A_RLD, 32'h5);
    idle(4);
    rd_chk("R4 divider busy cleared", A_STS, 32'h0);

    // R5/R6/R8 start with RL=5, D=8: pulses every 48 cycles
    wr(A_KEY, 32'hCCCC, kc);
    expect_pulse(kc + 48, "R5 first timeout");
    expect_pulse(kc + 96, "R8 reload and repeat");
    idle(100);
    chk("R8 queue drained", exp_q.size(), 0);
    do_reset();
    idle(30);
    chk("R8 reset stops watchdog", exp_q.size(), 0);

    // R7 refresh, and refresh colliding with the expiring tick
    wr(A_KEY, 32'h5555, kc);
    wr(A_RLD, 32'h3, kc);
    wr(A_DIV, 32'h0, kc);
    idle(4);
    wr(A_KEY, 32'hCCCC, kc);
    for (int i = 0; i < 4; i++) begin
      idle(9);
      wr(A_KEY, 32'hAAAA, kc);
    end
    idle(15);
    wr(A_KEY, 32'hAAAA, kc);
    expect_pulse(kc + 16, "R7 collision refresh wins");
    expect_pulse(kc + 32, "R8 periodic after collision");
    idle(40);
    chk("R7 queue drained", exp_q.size(), 0);
    do_reset();

    // R6 code 7 divides by 256
    wr(A_KEY, 32'h5555, kc);
    wr(A_DIV, 32'h7, kc);
    wr(A_RLD, 32'h1, kc);
    idle(4);
    wr(A_KEY, 32'hCCCC, kc);
    expect_pulse(kc + 512, "R6 code 7 divider 256");
    idle(520);
    chk("R6 queue drained", exp_q.size(), 0);
    do_reset();

    // R9 counting only on tick_en
    wr(A_KEY, 32'h5555, kc);
    wr(A_RLD, 32'h0, kc);
    idle(4);
    tick_en = 1'b0;
    wr(A_KEY, 32'hCCCC, kc);
    idle(50);
    tick_en = 1'b1;
    expect_pulse(kc + 54, "R9 resumes after tick gap");
    idle(8);
    chk("R9 queue drained", exp_q.size(), 0);
    do_reset();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule